// File: doc/BRIEF.md
# Diagonal Partial-Sum Convolution Tile

This block is a 3x3 grid of signed 8-bit multiply-accumulate cells that produces one 3x3 weighted sum per enabled clock cycle. On the left edge it receives one column of three feature values, one value for each grid row. On the top edge it receives one row of three weights, one value for each grid column. Inside the grid, feature values step one cell to the right on each enabled cycle and weights step one cell down.

No cell ever builds a complete result. The grid is divided into three wrap-around diagonal chains. The cells are numbered row-major from 0 to 8, and one chain is 0 -> 4 -> 8. Each cell in a chain accumulates three products and then adds the partial sum handed to it by the previous cell in the chain. The last cell of the chain therefore holds the full nine-product sum. The three chains are offset from one another by one cycle, so three kernels are always in flight at once.

A band-start flag marks the sample where the scan moves to the next band of three slice columns. A global enable freezes every register in the tile while the feeding stream stalls.

Top module: `diag_conv_tile`

## Requirements
- R1: While reset is asserted and after its release, `res_vld` reads 0 and `res_data` reads 0 until samples are captured.
- R2: Sample index n counts the enabled cycles after reset, starting at 0. Feature lane r is bits [8r+7:8r] of `feat_col`, written f_r(n). Weight lane c is bits [8c+7:8c] of `wgt_row`, written w_c(n). All values are two's complement. A result J with J mod 3 = 0 equals the sum over r and k (each 0..2) of f_r(J+k) * w_r(J+k).
- R3: For a result J with p = J mod 3 equal to 1 or 2, each row r pairs with weight lane c = (p + r) mod 3. The result equals the sum over r and k of f_r(J+k+r-c) * w_c(J+k).
- R4: Result J appears on the outputs just after the enabled edge that captures sample J+7. Samples 0 to 6 leave `res_vld` at 0. Starting with sample 7, each enabled edge presents the next result with no gap.
- R5: When `band_start` is high with sample B, results B-2 and B-1 carry `res_vld` = 0. This is a two-cycle gap in the output stream. Every other result stays valid.
- R6: In a cycle with `en` low, no state changes. The outputs hold their values, and the feature, weight and band inputs of that cycle are ignored. Results remain a function of the enabled-sample index alone.
- R7: The result is 24-bit signed and exact at the range limits. For example, nine products of (-128)*(-128) give 147456, and nine products of 127*(-128) give -146304.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample present; when low, every register holds |
| band_start | input | 1 | Marks the first sample of a new three-column band |
| feat_col | input | 24 | Three signed 8-bit feature lanes, one per grid row |
| wgt_row | input | 24 | Three signed 8-bit weight lanes, one per grid column |
| res_data | output | 24 | Signed completed 3x3 sum |
| res_vld | output | 1 | High when `res_data` holds a valid result |

## Verification
The range assertion assumes that each input lane is an 8-bit two's complement value, so that nine products can never leave plus or minus 147456. The row and shift assertions assume that `en` is the only qualifier on data movement, and that `band_start` means something only when `en` is high. The stimulus holds reset across the first edges of every scenario. It raises `band_start` only on enabled cycles, and during stalled cycles it drives random lane values to show that they are ignored. Every stream it sends is longer than the seven-sample fill, so that every result index, in all three chain phases, is compared with the sum computed from the sample tables.

// File: rtl/dct_pkg.sv
package dct_pkg;
    // kernel edge length; the chain and phase wiring is written for 3
    localparam int KS  = 3;
    // width of the shared step phase
    localparam int PHW = 2;
    // enabled edges from capture of sample J to presentation of result J
    localparam int LAT = 2 * KS + 1;
    // step phase held after reset (step index -2 modulo KS)
    localparam int PH_RST = KS - 2;
endpackage

// File: rtl/dct_pe.sv
module dct_pe
    import dct_pkg::*;
#(
    parameter int DW = 8,
    parameter int SW = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 is_end,
    input  logic signed [DW-1:0] f_in,
    input  logic signed [DW-1:0] w_in,
    input  logic signed [SW-1:0] psum_in,
    output logic signed [DW-1:0] f_q,
    output logic signed [DW-1:0] w_q,
    output logic signed [SW-1:0] sum_q
);
    localparam int PW = 2 * DW;
    localparam int LIM = KS * KS * (1 << (PW - 2));
    localparam logic signed [SW-1:0] LIM_S = SW'(LIM);

    typedef struct packed {
        logic signed [DW-1:0] f;
        logic signed [DW-1:0] w;
        logic signed [SW-1:0] acc;
        logic signed [SW-1:0] sum;
    } pe_st_t;

    pe_st_t st_q, st_d;
    logic signed [PW-1:0] prod;
    logic signed [SW-1:0] prod_x;

    always_comb begin
        prod   = st_q.f * st_q.w;
        prod_x = {{(SW - PW){prod[PW-1]}}, prod};
        st_d   = st_q;
        if (en) begin
            st_d.f = f_in;
            st_d.w = w_in;
            if (is_end) begin
                // last of three products: fold in the chain predecessor
                st_d.sum = st_q.acc + prod_x + psum_in;
                st_d.acc = '0;
            end else begin
                st_d.acc = st_q.acc + prod_x;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign f_q   = st_q.f;
    assign w_q   = st_q.w;
    assign sum_q = st_q.sum;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (st_q.sum <= LIM_S) && (st_q.sum >= -LIM_S)); // R7
    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st_q.acc <= LIM_S) && (st_q.acc >= -LIM_S)); // R7
endmodule

// File: rtl/dct_ctrl.sv
module dct_ctrl
    import dct_pkg::*;
#(
    parameter int VD = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           band_in,
    output logic [PHW-1:0] ph,
    output logic           vld
);
    localparam int CW = 4;
    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        logic [PHW-1:0] ph;
        logic [KS-2:0]  ex;   // sample n-1 / n-2 existed
        logic           bs;   // band flag of sample n-1
        logic [VD-1:0]  vl;   // validity line toward the output
        logic [CW-1:0]  cnt;  // captured samples, saturating
    } ctl_st_t;

    ctl_st_t st_q, st_d;
    logic    v_new;

    always_comb begin
        st_d  = st_q;
        v_new = st_q.ex[KS-2] & ~st_q.bs & ~band_in;
        if (en) begin
            st_d.ph  = (st_q.ph == PHW'(KS - 1)) ? '0 : st_q.ph + 1'b1;
            st_d.ex  = {st_q.ex[KS-3:0], 1'b1};
            st_d.bs  = band_in;
            st_d.vl  = {st_q.vl[VD-2:0], v_new};
            st_d.cnt = (st_q.cnt == CMAX) ? st_q.cnt : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            st_q.ph <= PHW'(PH_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign ph  = st_q.ph;
    assign vld = st_q.vl[VD-1];

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        st_q.ph < PHW'(KS)); // R2
    AST_WARMUP: assert property (@(posedge clk) disable iff (rst)
        vld |-> (st_q.cnt >= CW'(LAT + 1))); // R4
endmodule

// File: rtl/dct_grid.sv
module dct_grid
    import dct_pkg::*;
#(
    parameter int DW = 8,
    parameter int SW = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [KS-1:0][DW-1:0]    f_col,
    input  logic [KS-1:0][DW-1:0]    w_row,
    input  logic [PHW-1:0]           ph,
    output logic [KS-1:0][SW-1:0]    last_row
);
    logic signed [DW-1:0] fq   [KS][KS];
    logic signed [DW-1:0] wq   [KS][KS];
    logic signed [SW-1:0] sq   [KS][KS];
    logic signed [DW-1:0] fin  [KS][KS];
    logic signed [DW-1:0] win  [KS][KS];
    logic signed [SW-1:0] pin  [KS][KS];
    logic [KS-1:0]        endv [KS];

    for (genvar r = 0; r < KS; r++) begin : g_row
        for (genvar c = 0; c < KS; c++) begin : g_col
            // cell (r,c) closes its group when the step phase is c+2 mod KS;
            // its chain predecessor sits one row up, one column left (wrapping)
            localparam int EC = (c + KS - 1) % KS;
            localparam int PC = (c + KS - 1) % KS;

            assign endv[r][c] = (ph == PHW'(EC));

            if (c == 0) begin : g_fl
                assign fin[r][c] = signed'(f_col[r]);
            end else begin : g_fi
                assign fin[r][c] = fq[r][c-1];
            end

            if (r == 0) begin : g_wt
                assign win[r][c] = signed'(w_row[c]);
                assign pin[r][c] = '0;
            end else begin : g_wi
                assign win[r][c] = wq[r-1][c];
                assign pin[r][c] = sq[r-1][PC];
            end

            dct_pe #(.DW(DW), .SW(SW)) u_pe (
                .clk     (clk),
                .rst     (rst),
                .en      (en),
                .is_end  (endv[r][c]),
                .f_in    (fin[r][c]),
                .w_in    (win[r][c]),
                .psum_in (pin[r][c]),
                .f_q     (fq[r][c]),
                .w_q     (wq[r][c]),
                .sum_q   (sq[r][c])
            );
        end

        assign last_row[r] = sq[KS-1][r];

        AST_ROW_ONE_END: assert property (@(posedge clk) disable iff (rst)
            $onehot(endv[r])); // R2
        AST_FEAT_EXIT: assert property (@(posedge clk) disable iff (rst)
            en |=> (fq[r][KS-1] == $past(fq[r][KS-2]))); // R2
        AST_WGT_EXIT: assert property (@(posedge clk) disable iff (rst)
            en |=> (wq[KS-1][r] == $past(wq[KS-2][r]))); // R3
    end
endmodule

// File: rtl/diag_conv_tile.sv
module diag_conv_tile
    import dct_pkg::*;
#(
    parameter int DW = 8,
    parameter int SW = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 band_start,
    input  logic [KS*DW-1:0]     feat_col,
    input  logic [KS*DW-1:0]     wgt_row,
    output logic signed [SW-1:0] res_data,
    output logic                 res_vld
);
    localparam int VD = LAT - KS + 2;

    typedef struct packed {
        logic [KS-1:0][DW-1:0] lf;   // launch stage, features
        logic [KS-1:0][DW-1:0] lw;   // launch stage, weights
        logic [SW-1:0]         res;  // collect stage
    } top_st_t;

    top_st_t st_q, st_d;
    logic [PHW-1:0]        ph;
    logic [KS-1:0][SW-1:0] last_row;

    dct_ctrl #(.VD(VD)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .band_in (band_start),
        .ph      (ph),
        .vld     (res_vld)
    );

    dct_grid #(.DW(DW), .SW(SW)) u_grid (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .f_col    (st_q.lf),
        .w_row    (st_q.lw),
        .ph       (ph),
        .last_row (last_row)
    );

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.lf  = feat_col;
            st_d.lw  = wgt_row;
            // the bottom cell whose chain closed last step sits in column ph
            st_d.res = last_row[ph];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_data = st_q.res;

    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(res_data) && $stable(res_vld))); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!res_vld && (res_data == '0))); // R1
endmodule

// File: tb/sim_diag_conv_tile.sv
module sim_diag_conv_tile;
    localparam int CLK_P = 10;
    localparam int MAXS  = 100;
    localparam int LATB  = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic        band_start = 1'b0;
    logic [23:0] feat_col = '0;
    logic [23:0] wgt_row  = '0;
    logic signed [23:0] res_data;
    logic        res_vld;

    int total = 0;
    int bad   = 0;
    int fa [3][MAXS];
    int wb [3][MAXS];
    bit bsf [MAXS];

    diag_conv_tile u0 (
        .clk(clk), .rst(rst), .en(en), .band_start(band_start),
        .feat_col(feat_col), .wgt_row(wgt_row),
        .res_data(res_data), .res_vld(res_vld)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint exp_res(int j);
        longint s = 0;
        int p = j % 3;
        for (int r = 0; r < 3; r++) begin
            int c = (p + r) % 3;
            for (int k = 0; k < 3; k++) begin
                int idx = j + k + r - c;
                if (idx >= 0) s += longint'(fa[r][idx]) * longint'(wb[c][j + k]);
            end
        end
        return s;
    endfunction

    task automatic fill_rand();
        for (int n = 0; n < MAXS; n++) begin
            bsf[n] = 1'b0;
            for (int r = 0; r < 3; r++) begin
                fa[r][n] = int'($urandom_range(0, 255)) - 128;
                wb[r][n] = int'($urandom_range(0, 255)) - 128;
            end
        end
    endtask

    task automatic fill_const(int fv, int wv);
        for (int n = 0; n < MAXS; n++) begin
            bsf[n] = 1'b0;
            for (int r = 0; r < 3; r++) begin
                fa[r][n] = fv;
                wb[r][n] = wv;
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en  = 1'b0;
        band_start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_capture(int s, string dtag);
        int j = s - LATB;
        if (j < 0) begin
            chk("R4 fill", longint'(res_vld), 0);
        end else begin
            bit ev = !(bsf[j + 1] || bsf[j + 2]);
            chk(ev ? "R4 valid" : "R5 gap", longint'(res_vld), longint'(ev));
            if (ev && res_vld) begin
                string t = (dtag != "") ? dtag : ((j % 3 == 0) ? "R2" : "R3");
                chk(t, longint'(res_data), exp_res(j));
            end
        end
    endtask

    task automatic run_stream(int len, int stall_every, string dtag);
        int s = 0;
        int cyc = 0;
        bit en_prev = 1'b0;
        logic signed [23:0] pd;
        logic pv;
        while (s < len) begin
            @(negedge clk);
            if (cyc > 0) begin
                if (en_prev) check_capture(s - 1, dtag);
                else begin
                    chk("R6 hold data", longint'(res_data), longint'(pd));
                    chk("R6 hold vld", longint'(res_vld), longint'(pv));
                end
            end
            pd = res_data;
            pv = res_vld;
            if (stall_every > 0 && (cyc % stall_every) == stall_every - 1) begin
                en = 1'b0;
                feat_col = 24'($urandom);
                wgt_row  = 24'($urandom);
                band_start = 1'($urandom_range(0, 1));
                en_prev = 1'b0;
            end else begin
                en = 1'b1;
                feat_col = {8'(fa[2][s]), 8'(fa[1][s]), 8'(fa[0][s])};
                wgt_row  = {8'(wb[2][s]), 8'(wb[1][s]), 8'(wb[0][s])};
                band_start = bsf[s];
                en_prev = 1'b1;
                s++;
            end
            cyc++;
        end
        @(negedge clk);
        check_capture(s - 1, dtag);
        en = 1'b0;
        band_start = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 vld", longint'(res_vld), 0);
        chk("R1 data", longint'(res_data), 0);
        repeat (3) @(negedge clk);
        chk("R1 idle vld", longint'(res_vld), 0);
        chk("R1 idle data", longint'(res_data), 0);
    endtask

    task automatic t_random();
        do_reset();
        fill_rand();
        run_stream(60, 0, "");
    endtask

    task automatic t_bands();
        do_reset();
        fill_rand();
        bsf[20] = 1'b1;
        bsf[33] = 1'b1;
        bsf[47] = 1'b1;
        run_stream(70, 0, "");
    endtask

    task automatic t_stall();
        do_reset();
        fill_rand();
        bsf[25] = 1'b1;
        run_stream(50, 4, "");
    endtask

    task automatic t_extreme();
        do_reset();
        fill_const(-128, -128);
        run_stream(30, 0, "R7 max");
        do_reset();
        fill_const(127, -128);
        run_stream(30, 0, "R7 min");
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_random();
        t_bands();
        t_stall();
        t_extreme();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule